// File: doc/BRIEF.md
# Gated Memory Replay Sequencer

This block steps through a region of stored samples, but only while a gate input is high. In every clock cycle where the sequencer is running and the gate is high, it puts out one memory read address and one sample-valid pulse. When the gate drops, output pauses and the read position holds until the gate rises again. A start strobe arms the block and clears its counters. A stop strobe takes it back to idle. When its configured end condition is met, the block stops itself and raises a done flag.

Two operating modes are selected by a mode code. In the standard mode, the block addresses an external sample memory of programmable size and wraps back to address 0 at its end. The loop count gives the end condition. Zero means play until stopped. One means play the memory exactly once, cutting the current gate short. N≥2 means stop after N complete gates. In the streaming mode, samples are pulled from a ready/valid input instead. A gate cycle with no input word available raises an underrun flag. A nonzero loop count ends playback after that many gates.

Top module: `gated_replay_seq`

## Requirements
- R1: sampleValid is high in a cycle only if running and gateIn are both high in that cycle. In standard mode, every such cycle gives exactly one sampleValid.
- R2: rdAddr advances by one after each cycle that has sampleValid, unless it wraps. It holds its value in every cycle without sampleValid, except after an accepted start.
- R3: In standard mode, a sample at address cfgMemSize−1 is followed by address 0 on the next sample, with no idle cycle. With loop count 0 the block keeps running until stopped.
- R4: In standard mode with loop count 1, the block stops at the clock edge after the cfgMemSize-th sample, even when the gate is still high. It then shows running=0 and done=1.
- R5: In standard mode with loop count N≥2, the block keeps running through the first N−1 gate falls. It stops at the edge that ends the cycle in which gate N is seen low, so running=0 and done=1 from the next cycle.
- R6: cfgMode 0x0400 selects standard mode and 0x2000 selects streaming mode. A start with any other code, or a standard start with cfgMemSize 0, is ignored and running stays 0.
- R7: In streaming mode, streamReady equals running AND gateIn, and sampleValid equals streamReady AND streamValid. sampleData equals streamData.
- R8: In streaming mode, a cycle with running, gateIn high and streamValid low raises underrun and has no sampleValid.
- R9: In streaming mode, a nonzero loop count N stops the block after the gate-low cycle that follows the N-th gate. Loop count 0 keeps it running across gates.
- R10: A stop strobe makes running 0 from the next cycle and leaves done unchanged. A stop takes priority over a simultaneous start.
- R11: An accepted start clears the address, sample and gate counters and clears done. The first sample after it reads address 0.
- R12: After reset, running, done, sampleValid, streamReady and underrun are 0 and rdAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 16 | Mode code: 0x0400 standard, 0x2000 streaming |
| cfgMemSize | input | CNT_W | Number of samples in memory (standard mode) |
| cfgLoops | input | LOOP_W | Loop/gate count |
| startPulse | input | 1 | Start strobe, one cycle |
| stopPulse | input | 1 | Stop strobe, one cycle |
| gateIn | input | 1 | Gate condition |
| streamData | input | DATA_W | Streaming input word |
| streamValid | input | 1 | Streaming input word available |
| streamReady | output | 1 | Streaming input word taken this cycle |
| rdAddr | output | ADDR_W | Memory read address |
| sampleValid | output | 1 | Sample emitted this cycle |
| sampleData | output | DATA_W | Streamed word (zero in standard mode) |
| underrun | output | 1 | Gate active but streaming input empty |
| running | output | 1 | Playback active |
| done | output | 1 | Playback ended on its own |

## Verification
A wrong address or wrap value shows on rdAddr at the very next sample. A missed wrap after cfgMemSize−1 is visible one cycle later as a non-zero address. A wrong gate count or a wrong loop decode shows as running staying high, or dropping, at the one edge after the deciding gate fall or last sample. Since done and running are compared in that same cycle, an off-by-one gate or sample count leaves a one-cycle discrepancy that the bench catches. Underrun or ready errors in streaming mode show up in the same cycle as the gate and valid levels that cause them.

// File: rtl/grs_pkg.sv
package grs_pkg;
  localparam logic [15:0] MODE_STD  = 16'h0400;
  localparam logic [15:0] MODE_STRM = 16'h2000;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // reset all counters (accepted start)
    logic advance;   // one sample emitted this cycle
    logic gateFall;  // gate seen falling while running
  } grsStrobe_t;
endpackage

// File: rtl/grs_datapath.sv
module grs_datapath
  import grs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  grsStrobe_t        strobe,
  input  logic [CNT_W-1:0]  memSize,
  input  logic [LOOP_W-1:0] loops,
  output logic [ADDR_W-1:0] addr,
  output logic              lastSample,
  output logic              gateCntHit
);
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  sampleCnt;
  logic [LOOP_W-1:0] gateCnt;
  logic [CNT_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  addrWide;
  logic              addrAtEnd;
  logic [LOOP_W:0]   gateNext;

  assign lastIdx   = memSize - CNT_W'(1);
  assign addrWide  = CNT_W'(addrQ);
  assign addrAtEnd = (addrWide == lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.clear) begin
      addrQ <= '0;
    end else if (strobe.advance) begin
      addrQ <= addrAtEnd ? '0 : addrQ + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
    end else if (strobe.clear) begin
      sampleCnt <= '0;
    end else if (strobe.advance) begin
      sampleCnt <= sampleCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateCnt <= '0;
    end else if (strobe.clear) begin
      gateCnt <= '0;
    end else if (strobe.gateFall) begin
      gateCnt <= gateCnt + LOOP_W'(1);
    end
  end

  assign gateNext   = {1'b0, gateCnt} + (LOOP_W+1)'(1);
  assign gateCntHit = (gateNext == {1'b0, loops});
  assign lastSample = (sampleCnt == lastIdx);
  assign addr       = addrQ;
endmodule

// File: rtl/grs_ctrl.sv
module grs_ctrl
  import grs_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cfgMode,
  input  logic [CNT_W-1:0]  cfgMemSize,
  input  logic [LOOP_W-1:0] cfgLoops,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              gateIn,
  input  logic              streamValid,
  input  logic              lastSample,
  input  logic              gateCntHit,
  output grsStrobe_t        strobe,
  output logic              runQ,
  output logic              doneQ,
  output logic              strmQ,
  output logic              gateAct,
  output logic              fire
);
  logic modeStd, modeStrm, modeOk, accept;
  logic loopsZero, loopsOne;
  logic gatePrev, fall, endMem, endGate;

  assign modeStd   = (cfgMode == MODE_STD);
  assign modeStrm  = (cfgMode == MODE_STRM);
  assign modeOk    = (modeStd && (cfgMemSize != '0)) || modeStrm;
  assign accept    = startPulse && !stopPulse && modeOk;
  assign loopsZero = (cfgLoops == '0);
  assign loopsOne  = (cfgLoops == LOOP_W'(1));

  assign gateAct = runQ && gateIn;
  assign fire    = gateAct && (!strmQ || streamValid);
  assign fall    = runQ && gatePrev && !gateIn;

  // standard mode, loop count 1: memory exhaustion ends playback
  assign endMem  = fire && !strmQ && loopsOne && lastSample;
  // gate-count based ending
  assign endGate = fall && !loopsZero && gateCntHit && (strmQ || !loopsOne);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      doneQ <= 1'b0;
      strmQ <= 1'b0;
    end else if (stopPulse) begin
      runQ  <= 1'b0;
    end else if (accept) begin
      runQ  <= 1'b1;
      doneQ <= 1'b0;
      strmQ <= modeStrm;
    end else if (runQ && (endMem || endGate)) begin
      runQ  <= 1'b0;
      doneQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
    end else if (accept || stopPulse) begin
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gateAct;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clear    = accept;
    strobe.advance  = fire;
    strobe.gateFall = fall;
  end
endmodule

// File: rtl/gated_replay_seq.sv
module gated_replay_seq
  import grs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cfgMode,
  input  logic [CNT_W-1:0]  cfgMemSize,
  input  logic [LOOP_W-1:0] cfgLoops,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              gateIn,
  input  logic [DATA_W-1:0] streamData,
  input  logic              streamValid,
  output logic              streamReady,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              underrun,
  output logic              running,
  output logic              done
);
  grsStrobe_t strobe;
  logic lastSample, gateCntHit;
  logic runQ, doneQ, strmQ, gateAct, fire;

  grs_ctrl #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgMode(cfgMode), .cfgMemSize(cfgMemSize), .cfgLoops(cfgLoops),
    .startPulse(startPulse), .stopPulse(stopPulse),
    .gateIn(gateIn), .streamValid(streamValid),
    .lastSample(lastSample), .gateCntHit(gateCntHit),
    .strobe(strobe), .runQ(runQ), .doneQ(doneQ), .strmQ(strmQ),
    .gateAct(gateAct), .fire(fire)
  );

  grs_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memSize(cfgMemSize), .loops(cfgLoops),
    .addr(rdAddr), .lastSample(lastSample), .gateCntHit(gateCntHit)
  );

  assign sampleValid = fire;
  assign streamReady = gateAct && strmQ;
  assign underrun    = gateAct && strmQ && !streamValid;
  assign sampleData  = strmQ ? streamData : '0;
  assign running     = runQ;
  assign done        = doneQ;
endmodule

// File: rtl/grs_checker.sv
module grs_checker
  import grs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cfgMode,
  input logic [CNT_W-1:0]  cfgMemSize,
  input logic              startPulse,
  input logic              stopPulse,
  input logic              gateIn,
  input logic              streamReady,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              sampleValid,
  input logic              underrun,
  input logic              running,
  input logic              done
);
  logic [ADDR_W-1:0] lastA;
  logic              startOk;
  assign lastA   = cfgMemSize[ADDR_W-1:0] - ADDR_W'(1);
  assign startOk = startPulse && !stopPulse &&
                   ((cfgMode == MODE_STD && cfgMemSize != '0) || cfgMode == MODE_STRM);

  a_r1_valid_in_gate: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (gateIn && running));

  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !startPulse) |=> $stable(rdAddr));

  a_r2_step_addr: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !startPulse && rdAddr != lastA) |=> (rdAddr == $past(rdAddr) + ADDR_W'(1)));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !startPulse && cfgMode == MODE_STD && rdAddr == lastA) |=> (rdAddr == '0));

  a_r8_underrun_no_sample: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (!sampleValid && streamReady));

  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !running);

  a_r10_done_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && done) |=> done);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> (rdAddr == '0 && running && !done));

  a_r4_run_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(running && done));
endmodule

bind gated_replay_seq grs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgMemSize(cfgMemSize),
  .startPulse(startPulse), .stopPulse(stopPulse), .gateIn(gateIn),
  .streamReady(streamReady), .rdAddr(rdAddr), .sampleValid(sampleValid),
  .underrun(underrun), .running(running), .done(done)
);

// File: tb/test_gated_replay_seq.sv
module test_gated_replay_seq;
  localparam int ADDR_W = 16, CNT_W = 32, LOOP_W = 32, DATA_W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] cfgMode = '0;
  logic [CNT_W-1:0] cfgMemSize = '0;
  logic [LOOP_W-1:0] cfgLoops = '0;
  logic startPulse = 0, stopPulse = 0, gateIn = 0, streamValid = 0;
  logic [DATA_W-1:0] streamData = '0;
  logic streamReady, sampleValid, underrun, running, done;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] sampleData;
  int nChecks = 0, nFails = 0;

  gated_replay_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W), .DATA_W(DATA_W)) i_gated_replay_seq (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgMemSize(cfgMemSize), .cfgLoops(cfgLoops),
    .startPulse(startPulse), .stopPulse(stopPulse), .gateIn(gateIn),
    .streamData(streamData), .streamValid(streamValid), .streamReady(streamReady),
    .rdAddr(rdAddr), .sampleValid(sampleValid), .sampleData(sampleData),
    .underrun(underrun), .running(running), .done(done)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cyc(input logic g, input logic v);
    tick();
    startPulse = 0; stopPulse = 0; gateIn = g; streamValid = v;
    #1;
  endtask

  task automatic doStart(input logic [15:0] m, input logic [31:0] sz, input logic [31:0] lp);
    tick();
    cfgMode = m; cfgMemSize = sz; cfgLoops = lp;
    startPulse = 1; stopPulse = 0; gateIn = 0; streamValid = 0;
    #1;
  endtask

  task automatic doStop();
    tick();
    startPulse = 0; stopPulse = 1; gateIn = 0;
    #1;
  endtask

  task automatic t_reset();
    check("R12 running", running, 0);
    check("R12 done", done, 0);
    check("R12 valid", sampleValid, 0);
    check("R12 ready", streamReady, 0);
    check("R12 underrun", underrun, 0);
    check("R12 addr", rdAddr, 0);
  endtask

  task automatic t_std_loop0();
    doStart(16'h0400, 4, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(1, 0);
      check("R1 valid in gate", sampleValid, 1);
      check("R3 addr wrap", rdAddr, i % 4);
    end
    cyc(0, 0);
    check("R1 no valid without gate", sampleValid, 0);
    check("R2 addr holds", rdAddr, 2);
    cyc(0, 0);
    check("R2 addr still holds", rdAddr, 2);
    check("R3 still running", running, 1);
    doStart(16'h0400, 4, 0);
    cyc(1, 0);
    check("R11 start clears addr", rdAddr, 0);
    tick(); stopPulse = 1; startPulse = 0; gateIn = 1; #1;
    check("R10 valid in stop cycle", sampleValid, 1);
    cyc(1, 0);
    check("R10 idle after stop", running, 0);
    check("R10 no valid after stop", sampleValid, 0);
    check("R10 done unchanged", done, 0);
  endtask

  task automatic t_std_loop1();
    doStart(16'h0400, 5, 1);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0);
      check("R4 addr", rdAddr, i);
    end
    cyc(0, 0); cyc(0, 0);
    check("R4 running across gap", running, 1);
    cyc(1, 0); check("R4 addr 3", rdAddr, 3);
    cyc(1, 0); check("R4 addr 4 valid", sampleValid, 1);
    check("R4 last addr", rdAddr, 4);
    cyc(1, 0);
    check("R4 stopped mid gate", running, 0);
    check("R4 done", done, 1);
    check("R4 no valid", sampleValid, 0);
    doStop();
    cyc(0, 0);
    check("R10 stop keeps done", done, 1);
    doStart(16'h0400, 5, 1);
    cyc(0, 0);
    check("R11 start clears done", done, 0);
  endtask

  task automatic t_std_loopN();
    doStart(16'h0400, 8, 3);
    for (int g = 0; g < 3; g++) begin
      cyc(1, 0); check("R5 addr even", rdAddr, 2*g);
      cyc(1, 0); check("R5 addr odd", rdAddr, 2*g+1);
      cyc(0, 0); check("R5 running at fall", running, 1);
    end
    cyc(0, 0);
    check("R5 stopped after gate 3", running, 0);
    check("R5 done", done, 1);
  endtask

  task automatic t_stream();
    doStart(16'h2000, 0, 2);
    tick(); startPulse = 0; gateIn = 1; streamValid = 1; streamData = 16'hA5A5; #1;
    check("R7 valid", sampleValid, 1);
    check("R7 ready", streamReady, 1);
    check("R7 data", sampleData, 16'hA5A5);
    check("R7 addr", rdAddr, 0);
    cyc(1, 0);
    check("R8 underrun", underrun, 1);
    check("R8 no valid", sampleValid, 0);
    check("R7 ready while empty", streamReady, 1);
    cyc(1, 1);
    check("R8 addr held over underrun", rdAddr, 1);
    check("R8 no underrun", underrun, 0);
    cyc(0, 1);
    check("R7 no ready without gate", streamReady, 0);
    check("R9 running after gate 1", running, 1);
    cyc(1, 1); check("R9 gate 2 sample", sampleValid, 1);
    cyc(0, 0); check("R9 running at fall 2", running, 1);
    cyc(0, 0);
    check("R9 stopped after 2 gates", running, 0);
    check("R9 done", done, 1);
    doStart(16'h2000, 0, 0);
    for (int g = 0; g < 4; g++) begin
      cyc(1, 1); cyc(0, 0);
    end
    cyc(0, 0);
    check("R9 loops 0 keeps running", running, 1);
    doStop();
  endtask

  task automatic t_bad_mode();
    doStart(16'h0123, 4, 0);
    cyc(1, 0);
    check("R6 bad code ignored", running, 0);
    check("R6 no valid", sampleValid, 0);
    doStart(16'h0400, 0, 0);
    cyc(1, 0);
    check("R6 zero size ignored", running, 0);
    tick(); cfgMode = 16'h0400; cfgMemSize = 4; startPulse = 1; stopPulse = 1; #1;
    cyc(1, 0);
    check("R10 stop beats start", running, 0);
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    tick(); rstN = 1;
    cyc(0, 0);
    t_reset();
    t_std_loop0();
    t_std_loop1();
    t_std_loopN();
    t_stream();
    t_bad_mode();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule